// File: doc/BRIEF.md
# Receive Clock Link-Speed Classifier

This block finds out how fast an Ethernet PHY's receive clock is running and turns that into a link-speed verdict. In the receive clock domain, a free-running two-bit counter marks every fourth receive clock edge. Each mark is carried into the system clock domain as a one-cycle pulse. There, the pulses are counted over a gate window of fixed length measured in system clock cycles.

At the end of the window the count is compared against three tolerance bands. The bands sit around 2.5 MHz, 25 MHz and 125 MHz, each ±1 MHz. The result is reported as a two-bit speed code and a done pulse. The block also drives a mode bit that selects the byte-wide interface (0) or the nibble-wide interface (1).

The band limits are computed when the block is built, from the system clock frequency, the gate length and the tolerance, so no multiplier is needed at run time. A count that lands in no band raises a fail flag and leaves the mode bit untouched.

A measurement begins with a one-cycle start request while the block is idle. The system clock must run at least as fast as the receive clock; 125 MHz or more covers every link rate.

Top module: `rx_speed_classifier`

## Requirements
- R1: While reset is held and after its release, before any measurement: `donePulse`=0, `failFlag`=0, `speedCode`=2'b00, `modeMii`=0 and `pulseCount`=0.
- R2: `pulseCount`, updated with each `donePulse`, equals the number of receive-clock quarter periods inside the gate window, within ±2 of f_rx·GATE_CYCLES/(4·SYS_FREQ_HZ).
- R3: When `startReq` is high at clock edge E while the block is idle, `donePulse` is high for exactly one cycle, following edge E+GATE_CYCLES+1.
- R4: The speed code is 2'b00 when the count falls in the 2.5 MHz ±1 MHz band and 2'b01 in the 25 MHz ±1 MHz band. It is 2'b10 in the 125 MHz ±1 MHz band. All bands are inclusive at both ends, converted to count units.
- R5: A successful result sets `modeMii` to 1 for codes 2'b00 and 2'b01 and to 0 for code 2'b10.
- R6: A count in no band gives `speedCode`=2'b11 and `failFlag`=1, and leaves `modeMii` at its previous value.
- R7: A `startReq` sampled while a measurement is running, including its final evaluation cycle, has no effect: no extra or shifted `donePulse`.
- R8: A `startReq` sampled in the cycle in which `donePulse` is high starts a new measurement.
- R9: `speedCode`, `failFlag`, `modeMii` and `pulseCount` change only together with `donePulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkSys | input | 1 | System clock, at least as fast as the receive clock |
| clkRx | input | 1 | Receive clock under measurement |
| rst | input | 1 | Active-high reset, synchronous to clkSys, resynchronized internally for clkRx |
| startReq | input | 1 | Start a measurement when idle |
| donePulse | output | 1 | One-cycle strobe when a new result is valid |
| failFlag | output | 1 | Last measurement fell into no band |
| speedCode | output | 2 | 00 10M, 01 100M, 10 1G, 11 failure |
| modeMii | output | 1 | 1 = nibble-wide interface, 0 = byte-wide interface |
| pulseCount | output | 32 | Captured count of synchronized pulses in the last window |

## Verification
Two events can fall in the same system cycle: the end of one measurement, when `donePulse` is high, and the arrival of the next start request. The bench drives `startReq` in exactly the cycle `donePulse` is expected. It also drives a request one cycle earlier, during the evaluation cycle.

A reference model holds a queue of expected completion cycles and results. The model accepts a request only once the previous completion cycle has been reached. On every clock it compares the presence of `donePulse` against the model. So a request that is wrongly dropped or wrongly accepted shows up as a missing, early or extra pulse.

// File: rtl/spdclass_pkg.sv
package spdclass_pkg;

  typedef enum logic [1:0] {
    SPD_10   = 2'b00,
    SPD_100  = 2'b01,
    SPD_1000 = 2'b10,
    SPD_FAIL = 2'b11
  } speed_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic cntEn;
    logic capture;
  } meas_strobe_t;

  localparam int NUM_RATES = 3;

  // receive clock frequency expected for each link rate, index = speed code
  function automatic longint unsigned rateTargetHz(input int idx);
    case (idx)
      0:       return 64'd2_500_000;
      1:       return 64'd25_000_000;
      default: return 64'd125_000_000;
    endcase
  endfunction

  // lowest count (inclusive) belonging to a band, rounded up
  function automatic longint unsigned bandLoCount(input longint unsigned targetHz,
                                                  input longint unsigned bandHz,
                                                  input longint unsigned gateCycles,
                                                  input longint unsigned sysHz);
    longint unsigned den;
    den = 4 * sysHz;
    if (targetHz <= bandHz) return 64'd0;
    return ((targetHz - bandHz) * gateCycles + den - 1) / den;
  endfunction

  // highest count (inclusive) belonging to a band, rounded down
  function automatic longint unsigned bandHiCount(input longint unsigned targetHz,
                                                  input longint unsigned bandHz,
                                                  input longint unsigned gateCycles,
                                                  input longint unsigned sysHz);
    longint unsigned den;
    den = 4 * sysHz;
    return ((targetHz + bandHz) * gateCycles) / den;
  endfunction

endpackage

// File: rtl/rx_pulse_xfer.sv
module rx_pulse_xfer (
  input  logic clkRx,
  input  logic clkSys,
  input  logic rst,
  output logic sysPulse
);

  // reset bridged into the receive domain
  logic [1:0] rxRstPipe;
  logic       rxRst;

  always_ff @(posedge clkRx or posedge rst) begin
    if (rst) rxRstPipe <= 2'b11;
    else     rxRstPipe <= {rxRstPipe[0], 1'b0};
  end
  assign rxRst = rxRstPipe[1];

  // divide by four and toggle on each quarter mark
  logic [1:0] divCnt;
  logic       rxToggle;

  always_ff @(posedge clkRx) begin
    if (rxRst) begin
      divCnt   <= 2'd0;
      rxToggle <= 1'b0;
    end else begin
      divCnt <= divCnt + 2'd1;
      if (divCnt == 2'd0) rxToggle <= ~rxToggle;
    end
  end

  // two-flop synchronizer plus one stage for edge detection
  logic [2:0] syncQ;

  always_ff @(posedge clkSys) begin
    if (rst) syncQ <= 3'b000;
    else     syncQ <= {syncQ[1:0], rxToggle};
  end

  assign sysPulse = syncQ[2] ^ syncQ[1];

  // R2
  pulse_isolated_chk: assert property (@(posedge clkSys) disable iff (rst)
    sysPulse |=> !sysPulse);

endmodule

// File: rtl/speed_meas_ctrl.sv
module speed_meas_ctrl
  import spdclass_pkg::*;
#(
  parameter int unsigned GATE_CYCLES = 25_000_000
) (
  input  logic         clkSys,
  input  logic         rst,
  input  logic         startReq,
  output meas_strobe_t strobe
);

  localparam int WIN_W = $clog2(GATE_CYCLES);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(GATE_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_EVAL} ctrl_state_e;

  ctrl_state_e       state;
  logic [WIN_W-1:0]  winCnt;

  always_ff @(posedge clkSys) begin
    if (rst) begin
      state  <= ST_IDLE;
      winCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          winCnt <= '0;
          if (startReq) state <= ST_RUN;
        end
        ST_RUN: begin
          if (winCnt == WIN_LAST) state <= ST_EVAL;
          else                    winCnt <= winCnt + 1'b1;
        end
        ST_EVAL: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.clrCnt  = (state == ST_IDLE);
    strobe.cntEn   = (state == ST_RUN);
    strobe.capture = (state == ST_EVAL);
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clkSys) disable iff (rst)
    $onehot0({strobe.cntEn, strobe.capture, strobe.clrCnt}));

  // R7
  run_hold_chk: assert property (@(posedge clkSys) disable iff (rst)
    (state == ST_RUN && winCnt != WIN_LAST) |=> state == ST_RUN);

  // R3
  eval_after_run_chk: assert property (@(posedge clkSys) disable iff (rst)
    strobe.capture |=> strobe.clrCnt);

endmodule

// File: rtl/speed_meas_datapath.sv
module speed_meas_datapath
  import spdclass_pkg::*;
#(
  parameter int unsigned SYS_FREQ_HZ = 250_000_000,
  parameter int unsigned GATE_CYCLES = 25_000_000,
  parameter int unsigned BAND_HZ     = 1_000_000,
  parameter int unsigned CNT_W       = 32
) (
  input  logic             clkSys,
  input  logic             rst,
  input  logic             sysPulse,
  input  meas_strobe_t     strobe,
  output logic             donePulse,
  output logic             failFlag,
  output logic [1:0]       speedCode,
  output logic             modeMii,
  output logic [CNT_W-1:0] pulseCount
);

  logic [CNT_W-1:0] liveCnt;
  logic [63:0]      cntWide;
  logic [NUM_RATES-1:0] bandHit;
  speed_e           verdict;

  always_ff @(posedge clkSys) begin
    if (rst || strobe.clrCnt)          liveCnt <= '0;
    else if (strobe.cntEn && sysPulse) liveCnt <= liveCnt + 1'b1;
  end

  assign cntWide = 64'(liveCnt);

  for (genvar gi = 0; gi < NUM_RATES; gi++) begin : g_band
    localparam longint unsigned LO_CNT =
      bandLoCount(rateTargetHz(gi), 64'(BAND_HZ), 64'(GATE_CYCLES), 64'(SYS_FREQ_HZ));
    localparam longint unsigned HI_CNT =
      bandHiCount(rateTargetHz(gi), 64'(BAND_HZ), 64'(GATE_CYCLES), 64'(SYS_FREQ_HZ));
    assign bandHit[gi] = (cntWide >= LO_CNT) && (cntWide <= HI_CNT);
  end

  always_comb begin
    if      (bandHit[0]) verdict = SPD_10;
    else if (bandHit[1]) verdict = SPD_100;
    else if (bandHit[2]) verdict = SPD_1000;
    else                 verdict = SPD_FAIL;
  end

  always_ff @(posedge clkSys) begin
    if (rst) begin
      donePulse  <= 1'b0;
      failFlag   <= 1'b0;
      speedCode  <= SPD_10;
      modeMii    <= 1'b0;
      pulseCount <= '0;
    end else begin
      donePulse <= strobe.capture;
      if (strobe.capture) begin
        pulseCount <= liveCnt;
        speedCode  <= verdict;
        failFlag   <= (verdict == SPD_FAIL);
        if (verdict != SPD_FAIL) modeMii <= (verdict != SPD_1000);
      end
    end
  end

  // R3
  done_single_chk: assert property (@(posedge clkSys) disable iff (rst)
    donePulse |=> !donePulse);

  // R6
  fail_code_chk: assert property (@(posedge clkSys) disable iff (rst)
    donePulse |-> (failFlag == (speedCode == SPD_FAIL)));

  // R6
  fail_mode_hold_chk: assert property (@(posedge clkSys) disable iff (rst)
    (donePulse && failFlag) |-> modeMii == $past(modeMii));

  // R5
  mode_value_chk: assert property (@(posedge clkSys) disable iff (rst)
    (donePulse && !failFlag) |-> modeMii == (speedCode != SPD_1000));

  // R9
  result_stable_chk: assert property (@(posedge clkSys) disable iff (rst)
    !donePulse |-> ($stable(pulseCount) && $stable(speedCode) && $stable(modeMii)));

  // R2
  count_step_chk: assert property (@(posedge clkSys) disable iff (rst)
    (strobe.cntEn && !strobe.clrCnt && liveCnt != '1) |=>
      (liveCnt == $past(liveCnt) || liveCnt == $past(liveCnt) + 1'b1));

endmodule

// File: rtl/rx_speed_classifier.sv
module rx_speed_classifier
  import spdclass_pkg::*;
#(
  parameter int unsigned SYS_FREQ_HZ = 250_000_000,
  parameter int unsigned GATE_CYCLES = 25_000_000,
  parameter int unsigned BAND_HZ     = 1_000_000,
  parameter int unsigned CNT_W       = 32
) (
  input  logic             clkSys,
  input  logic             clkRx,
  input  logic             rst,
  input  logic             startReq,
  output logic             donePulse,
  output logic             failFlag,
  output logic [1:0]       speedCode,
  output logic             modeMii,
  output logic [CNT_W-1:0] pulseCount
);

  logic         sysPulse;
  meas_strobe_t strobe;

  rx_pulse_xfer u_xfer (
    .clkRx    (clkRx),
    .clkSys   (clkSys),
    .rst      (rst),
    .sysPulse (sysPulse)
  );

  speed_meas_ctrl #(
    .GATE_CYCLES (GATE_CYCLES)
  ) u_ctrl (
    .clkSys   (clkSys),
    .rst      (rst),
    .startReq (startReq),
    .strobe   (strobe)
  );

  speed_meas_datapath #(
    .SYS_FREQ_HZ (SYS_FREQ_HZ),
    .GATE_CYCLES (GATE_CYCLES),
    .BAND_HZ     (BAND_HZ),
    .CNT_W       (CNT_W)
  ) u_dp (
    .clkSys     (clkSys),
    .rst        (rst),
    .sysPulse   (sysPulse),
    .strobe     (strobe),
    .donePulse  (donePulse),
    .failFlag   (failFlag),
    .speedCode  (speedCode),
    .modeMii    (modeMii),
    .pulseCount (pulseCount)
  );

endmodule

// File: tb/rx_speed_classifier_bench.sv
`timescale 1ns/1ps
module rx_speed_classifier_bench;

  localparam int SYS_HZ = 250_000_000;
  localparam int GATE   = 10_000;
  localparam int BAND   = 1_000_000;

  logic        clkSys = 1'b0;
  logic        clkRx  = 1'b0;
  logic        rst    = 1'b1;
  logic        startReq = 1'b0;
  logic        donePulse, failFlag, modeMii;
  logic [1:0]  speedCode;
  logic [31:0] pulseCount;

  realtime rxHalf = 4.0;

  rx_speed_classifier #(
    .SYS_FREQ_HZ (SYS_HZ),
    .GATE_CYCLES (GATE),
    .BAND_HZ     (BAND),
    .CNT_W       (32)
  ) u_rx_speed_classifier (
    .clkSys (clkSys), .clkRx (clkRx), .rst (rst), .startReq (startReq),
    .donePulse (donePulse), .failFlag (failFlag), .speedCode (speedCode),
    .modeMii (modeMii), .pulseCount (pulseCount)
  );

  always #2 clkSys = ~clkSys;
  always begin #(rxHalf) clkRx = ~clkRx; end

  int tests = 0, fails = 0;
  int cycNow = 0;
  int lastDoneAt = 0;
  bit monOn = 0, finished = 0;

  int qAt[$], qCode[$], qNom[$];
  string qTag[$];

  int  mMode = 0;
  logic [1:0]  prevCode = 2'b00;
  logic        prevFail = 1'b0, prevMode = 1'b0;
  logic [31:0] prevCount = '0;

  always @(posedge clkSys) cycNow++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycNow);
    end
  endtask

  // called right after a negedge; the request is sampled at the next edge
  task automatic driveStart(input int code, input int nom, input string tag);
    startReq = 1'b1;
    if (cycNow >= lastDoneAt) begin
      lastDoneAt = cycNow + GATE + 2;
      qAt.push_back(lastDoneAt);
      qCode.push_back(code);
      qNom.push_back(nom);
      qTag.push_back(tag);
    end
    @(negedge clkSys);
    startReq = 1'b0;
  endtask

  task automatic waitCycle(input int c);
    while (cycNow < c) @(negedge clkSys);
  endtask

  always @(negedge clkSys) begin
    if (monOn && !finished) begin
      #0.5;
      begin
        bit expDone;
        expDone = (qAt.size() > 0) && (qAt[0] == cycNow);
        check(donePulse == expDone, "R3 R7 R8 done timing", donePulse, expDone);
        if (expDone) begin
          int code, nom;
          string tag;
          void'(qAt.pop_front());
          code = qCode.pop_front();
          nom  = qNom.pop_front();
          tag  = qTag.pop_front();
          if (code != 3) mMode = (code != 2) ? 1 : 0;
          check(int'(speedCode) == code, {tag, " R4 speed code"}, speedCode, code);
          check(failFlag == (code == 3), {tag, " R6 fail flag"}, failFlag, code == 3);
          check(int'(modeMii) == mMode, {tag, " R5 R6 mode"}, modeMii, mMode);
          check((int'(pulseCount) >= nom - 2) && (int'(pulseCount) <= nom + 2),
                {tag, " R2 count"}, pulseCount, nom);
        end else if (!donePulse) begin
          check(speedCode == prevCode && failFlag == prevFail &&
                modeMii == prevMode && pulseCount == prevCount,
                "R9 outputs held", pulseCount, prevCount);
        end
        prevCode = speedCode; prevFail = failFlag;
        prevMode = modeMii;   prevCount = pulseCount;
      end
    end
  end

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(negedge clkSys) begin
    if (cycNow > 150_000 && !finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycNow);
      summary();
    end
  end

  initial begin
    rst = 1'b1;
    repeat (20) @(negedge clkSys);
    check(donePulse == 0, "R1 done reset", donePulse, 0);
    check(failFlag == 0, "R1 fail reset", failFlag, 0);
    check(speedCode == 2'b00, "R1 code reset", speedCode, 0);
    check(modeMii == 0, "R1 mode reset", modeMii, 0);
    check(pulseCount == 0, "R1 count reset", pulseCount, 0);
    rst = 1'b0;
    repeat (50) @(negedge clkSys);
    check(donePulse == 0 && modeMii == 0 && pulseCount == 0, "R1 idle after reset",
          pulseCount, 0);
    monOn = 1;

    // 25 MHz receive clock -> 100 Mbit/s, nibble mode
    rxHalf = 20.0;
    repeat (20) @(negedge clkSys);
    driveStart(1, 250, "m1 25MHz");
    repeat (100) @(negedge clkSys);
    driveStart(0, 0, "R7 ignored mid-run");
    waitCycle(lastDoneAt - 1);
    driveStart(0, 0, "R7 ignored in eval");
    waitCycle(lastDoneAt + 30);

    // 50 MHz -> no band, mode stays 1
    rxHalf = 10.0;
    repeat (30) @(negedge clkSys);
    driveStart(3, 500, "m2 50MHz");
    waitCycle(lastDoneAt - 1);
    rxHalf = 4.0;
    waitCycle(lastDoneAt);
    // start in the same cycle as done: 125 MHz -> 1 Gbit/s, byte mode
    driveStart(2, 1250, "R8 m3 125MHz restart on done");
    waitCycle(lastDoneAt + 30);

    // 100 MHz -> no band, mode stays 0
    rxHalf = 5.0;
    repeat (30) @(negedge clkSys);
    driveStart(3, 1000, "m4 100MHz");
    waitCycle(lastDoneAt + 30);

    // 2.5 MHz -> 10 Mbit/s, nibble mode
    rxHalf = 200.0;
    repeat (30) @(negedge clkSys);
    driveStart(0, 25, "m5 2.5MHz");
    waitCycle(lastDoneAt + 20);

    check(qAt.size() == 0, "R3 all results seen", qAt.size(), 0);
    summary();
  end

endmodule